// File: doc/BRIEF.md
# Logic Analyzer Trigger Unit

This block decides, sample by sample, whether a logic analyzer capture should start. Every valid sample word is presented to a set of identical detector ports. Each port holds three detectors: a masked value match, an unsigned range compare and a per-bit edge detector that compares the sample with the previous valid one. That gives three hit bits per port.

All hit bits together form an index into a one-bit-wide lookup table. Software loads the table one entry at a time through an address, data and write-enable port, so any boolean function of the hits can be chosen at run time. The table output for a valid sample is registered and leaves the block as a single-cycle trigger pulse for a capture recorder. Detector settings are written through a small register port that selects a port number and a field code.

Top module: `lat_trigger_unit`

## Requirements
- R1: The match detector of a port hits when `(data & mask) == (value & mask)`; with a zero mask it hits on every sample.
- R2: The range detector of a port hits when `low <= data <= high`, both bounds inclusive and compared as unsigned numbers; with `low > high` it never hits.
- R3: The edge detector of a port hits when any bit set in the rise mask goes 0 to 1, any bit set in the fall mask goes 1 to 0, or any bit set in the any-edge mask changes, against the previous valid sample; with all three masks zero it never hits.
- R4: The previous sample is updated only on cycles with `smp_valid_i` high; the first valid sample after reset produces no edge hit.
- R5: The table index bit `3*p` is the match hit of port p, bit `3*p+1` its range hit and bit `3*p+2` its edge hit.
- R6: A table write with `tbl_we_i` high stores `tbl_dat_i` at `tbl_addr_i` and is used from the next cycle; a sample in the same cycle as the write is looked up in the old content.
- R7: `trig_o` is high for exactly the cycle after a valid sample whose table entry is 1, and low after every cycle with `smp_valid_i` low.
- R8: After reset every detector setting and every table entry is zero, so `trig_o` stays low until the table is programmed.
- R9: A register write with `cfg_we_i` high changes only port `cfg_port_i`, from the next cycle, with field codes 0 value, 1 mask, 2 low bound, 3 high bound, 4 rise mask, 5 fall mask, 6 any-edge mask; code 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample word is valid this cycle |
| smp_data_i | input | DATA_W | Sample word |
| cfg_we_i | input | 1 | Detector register write strobe |
| cfg_port_i | input | PORT_W | Detector port selected for the write |
| cfg_field_i | input | 3 | Field code of the write |
| cfg_wdata_i | input | DATA_W | Value written to the field |
| tbl_we_i | input | 1 | Table entry write strobe |
| tbl_addr_i | input | HIT_W | Table entry address |
| tbl_dat_i | input | 1 | Table entry value |
| trig_o | output | 1 | Registered trigger pulse |

## Verification
The trigger for a sample is due exactly one clock after the edge that takes the sample, while register and table writes take effect on the edge that takes them and so govern a sample only from the following cycle. The bench drives every input just after a falling edge, advances a behavioural model on the rising edge with the same ordering (lookup with the old state, then apply writes and the new previous sample), and compares `trig_o` with the model's value at the next falling edge, on every cycle after reset. Directed phases place samples on range bounds, single-bit transitions, invalid cycles between samples, a write in the same cycle as a sample and the first sample after reset, followed by a long random phase.

// File: rtl/ltu_pkg.sv
package ltu_pkg;
  localparam int unsigned DET_PER_PORT = 3;
  localparam int unsigned FLD_W = 3;

  typedef enum logic [FLD_W-1:0] {
    FLD_VALUE = 3'd0,
    FLD_MASK  = 3'd1,
    FLD_LOW   = 3'd2,
    FLD_HIGH  = 3'd3,
    FLD_RISE  = 3'd4,
    FLD_FALL  = 3'd5,
    FLD_ANY   = 3'd6,
    FLD_NONE  = 3'd7
  } ltu_field_e;

  // hit bit positions inside one port
  localparam int unsigned HIT_TERM  = 0;
  localparam int unsigned HIT_RANGE = 1;
  localparam int unsigned HIT_EDGE  = 2;
endpackage

// File: rtl/ltu_edge_det.sv
module ltu_edge_det #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] cur_i,
  input  logic [DATA_W-1:0] prev_i,
  input  logic              prev_vld_i,
  input  logic [DATA_W-1:0] rise_msk_i,
  input  logic [DATA_W-1:0] fall_msk_i,
  input  logic [DATA_W-1:0] any_msk_i,
  output logic              hit_o
);
  logic [DATA_W-1:0] rose, fell, chg;

  always_comb begin
    rose  = ~prev_i &  cur_i & rise_msk_i;
    fell  =  prev_i & ~cur_i & fall_msk_i;
    chg   = (prev_i ^ cur_i) & any_msk_i;
    hit_o = prev_vld_i & (|(rose | fell | chg));
  end
endmodule

// File: rtl/ltu_port.sv
module ltu_port
  import ltu_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned PORT_W  = 1,
  parameter int unsigned PORT_ID = 0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_we_i,
  input  logic [PORT_W-1:0]       cfg_port_i,
  input  logic [FLD_W-1:0]        cfg_field_i,
  input  logic [DATA_W-1:0]       cfg_wdata_i,
  input  logic [DATA_W-1:0]       cur_i,
  input  logic [DATA_W-1:0]       prev_i,
  input  logic                    prev_vld_i,
  output logic [DET_PER_PORT-1:0] hit_o
);
  logic [DATA_W-1:0] val_q, msk_q, low_q, high_q, rise_q, fall_q, any_q;
  logic              sel;
  logic              edge_hit;

  assign sel = cfg_we_i && (cfg_port_i == PORT_W'(PORT_ID));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q  <= '0;
      msk_q  <= '0;
      low_q  <= '0;
      high_q <= '0;
      rise_q <= '0;
      fall_q <= '0;
      any_q  <= '0;
    end else if (sel) begin
      case (ltu_field_e'(cfg_field_i))
        FLD_VALUE: val_q  <= cfg_wdata_i;
        FLD_MASK:  msk_q  <= cfg_wdata_i;
        FLD_LOW:   low_q  <= cfg_wdata_i;
        FLD_HIGH:  high_q <= cfg_wdata_i;
        FLD_RISE:  rise_q <= cfg_wdata_i;
        FLD_FALL:  fall_q <= cfg_wdata_i;
        FLD_ANY:   any_q  <= cfg_wdata_i;
        default: ;
      endcase
    end
  end

  ltu_edge_det #(.DATA_W(DATA_W)) u_edge (
    .cur_i      (cur_i),
    .prev_i     (prev_i),
    .prev_vld_i (prev_vld_i),
    .rise_msk_i (rise_q),
    .fall_msk_i (fall_q),
    .any_msk_i  (any_q),
    .hit_o      (edge_hit)
  );

  always_comb begin
    hit_o            = '0;
    hit_o[HIT_TERM]  = ((cur_i ^ val_q) & msk_q) == '0;
    hit_o[HIT_RANGE] = (cur_i >= low_q) && (cur_i <= high_q);
    hit_o[HIT_EDGE]  = edge_hit;
  end

  p_cfg_low_store_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && cfg_field_i == FLD_LOW) |=> (low_q == $past(cfg_wdata_i)));

  p_cfg_other_port_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel) |=> ($stable(val_q) && $stable(msk_q) && $stable(low_q) && $stable(high_q)));

  p_cfg_code7_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_field_i == FLD_NONE) |=> ($stable(rise_q) && $stable(fall_q) && $stable(any_q)));

  p_edge_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!prev_vld_i) |-> !hit_o[HIT_EDGE]);

  p_edge_zero_msk_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_q == '0 && fall_q == '0 && any_q == '0) |-> !hit_o[HIT_EDGE]);

  p_range_empty_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_q > high_q) |-> !hit_o[HIT_RANGE]);
endmodule

// File: rtl/ltu_lut.sv
module ltu_lut #(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_addr_i,
  input  logic             wr_dat_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] tbl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   tbl_q <= '0;
    else if (we_i) tbl_q[wr_addr_i] <= wr_dat_i;
  end

  assign rd_o = tbl_q[rd_idx_i];

  p_tbl_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (tbl_q[$past(wr_addr_i)] == $past(wr_dat_i)));

  p_tbl_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(tbl_q));
endmodule

// File: rtl/lat_trigger_unit.sv
module lat_trigger_unit
  import ltu_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned NUM_PORTS = 2,
  localparam int unsigned PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int unsigned HIT_W    = DET_PER_PORT * NUM_PORTS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_valid_i,
  input  logic [DATA_W-1:0] smp_data_i,
  input  logic              cfg_we_i,
  input  logic [PORT_W-1:0] cfg_port_i,
  input  logic [FLD_W-1:0]  cfg_field_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  input  logic              tbl_we_i,
  input  logic [HIT_W-1:0]  tbl_addr_i,
  input  logic              tbl_dat_i,
  output logic              trig_o
);
  logic [DATA_W-1:0] prev_q;
  logic              prev_vld_q;
  logic [HIT_W-1:0]  hits;
  logic              lut_out;
  logic              trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q     <= '0;
      prev_vld_q <= 1'b0;
    end else if (smp_valid_i) begin
      prev_q     <= smp_data_i;
      prev_vld_q <= 1'b1;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    ltu_port #(
      .DATA_W  (DATA_W),
      .PORT_W  (PORT_W),
      .PORT_ID (p)
    ) u_port (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cfg_we_i    (cfg_we_i),
      .cfg_port_i  (cfg_port_i),
      .cfg_field_i (cfg_field_i),
      .cfg_wdata_i (cfg_wdata_i),
      .cur_i       (smp_data_i),
      .prev_i      (prev_q),
      .prev_vld_i  (prev_vld_q),
      .hit_o       (hits[DET_PER_PORT*p +: DET_PER_PORT])
    );
  end

  ltu_lut #(.IDX_W(HIT_W)) u_lut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (tbl_we_i),
    .wr_addr_i (tbl_addr_i),
    .wr_dat_i  (tbl_dat_i),
    .rd_idx_i  (hits),
    .rd_o      (lut_out)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= 1'b0;
    else         trig_q <= smp_valid_i & lut_out;
  end

  assign trig_o = trig_q;

  p_trig_needs_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> $past(smp_valid_i));

  p_trig_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> !trig_o);

  p_prev_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> ($stable(prev_q) && $stable(prev_vld_q)));

  p_prev_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i |=> (prev_vld_q && prev_q == $past(smp_data_i)));
endmodule

// File: tb/test_lat_trigger_unit.sv
module test_lat_trigger_unit;
  localparam int DW = 16;
  localparam int NP = 2;
  localparam int PW = 1;
  localparam int HW = 3 * NP;
  localparam int TD = 1 << HW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          smp_valid_i = 1'b0;
  logic [DW-1:0] smp_data_i = '0;
  logic          cfg_we_i = 1'b0;
  logic [PW-1:0] cfg_port_i = '0;
  logic [2:0]    cfg_field_i = '0;
  logic [DW-1:0] cfg_wdata_i = '0;
  logic          tbl_we_i = 1'b0;
  logic [HW-1:0] tbl_addr_i = '0;
  logic          tbl_dat_i = 1'b0;
  logic          trig_o;

  int    n_chk = 0;
  int    n_err = 0;
  string cur_req = "R8";
  bit    finished = 0;

  always #2 clk = ~clk;

  lat_trigger_unit #(.DATA_W(DW), .NUM_PORTS(NP)) i_lat_trigger_unit (
    .clk_i(clk), .rst_ni(rst_ni), .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i),
    .cfg_we_i(cfg_we_i), .cfg_port_i(cfg_port_i), .cfg_field_i(cfg_field_i),
    .cfg_wdata_i(cfg_wdata_i), .tbl_we_i(tbl_we_i), .tbl_addr_i(tbl_addr_i),
    .tbl_dat_i(tbl_dat_i), .trig_o(trig_o)
  );

  // behavioural reference: cfg[p][code], code 0..6
  bit [DW-1:0] m_cfg [NP][7];
  bit          m_tbl [TD];
  bit [DW-1:0] m_prev;
  bit          m_pv;
  bit          exp_trig;

  function automatic int calc_idx(input bit [DW-1:0] d);
    int idx = 0;
    for (int p = 0; p < NP; p++) begin
      bit t, r, e;
      bit [DW-1:0] v, ch;
      t = ((d & m_cfg[p][1]) == (m_cfg[p][0] & m_cfg[p][1]));
      r = (d >= m_cfg[p][2]) && (d <= m_cfg[p][3]);
      e = 0;
      if (m_pv) begin
        for (int b = 0; b < DW; b++) begin
          if (m_cfg[p][4][b] && !m_prev[b] && d[b]) e = 1;
          if (m_cfg[p][5][b] && m_prev[b] && !d[b]) e = 1;
          if (m_cfg[p][6][b] && (m_prev[b] != d[b])) e = 1;
        end
      end
      v = '0; ch = '0;
      if (t) idx += 1 << (3*p);
      if (r) idx += 1 << (3*p + 1);
      if (e) idx += 1 << (3*p + 2);
    end
    return idx;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < NP; p++)
        for (int f = 0; f < 7; f++) m_cfg[p][f] = '0;
      for (int a = 0; a < TD; a++) m_tbl[a] = 0;
      m_prev   = '0;
      m_pv     = 0;
      exp_trig = 0;
    end else begin
      exp_trig = smp_valid_i && m_tbl[calc_idx(smp_data_i)];
      if (cfg_we_i && cfg_field_i != 3'd7) m_cfg[cfg_port_i][cfg_field_i] = cfg_wdata_i;
      if (tbl_we_i) m_tbl[tbl_addr_i] = tbl_dat_i;
      if (smp_valid_i) begin
        m_prev = smp_data_i;
        m_pv   = 1;
      end
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: trig_o=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk)
    if (rst_ni && !finished) check(cur_req, trig_o, exp_trig);

  task automatic cfg_write(input int p, input int f, input logic [DW-1:0] v);
    cfg_we_i = 1; cfg_port_i = PW'(p); cfg_field_i = 3'(f); cfg_wdata_i = v;
    @(negedge clk);
    cfg_we_i = 0;
  endtask

  task automatic tbl_write(input int a, input bit b);
    tbl_we_i = 1; tbl_addr_i = HW'(a); tbl_dat_i = b;
    @(negedge clk);
    tbl_we_i = 0;
  endtask

  // table = index bit 'pos'
  task automatic load_fn(input int pos);
    for (int a = 0; a < TD; a++) tbl_write(a, a[pos]);
  endtask

  task automatic sample(input logic [DW-1:0] d);
    smp_valid_i = 1; smp_data_i = d;
    @(negedge clk);
    smp_valid_i = 0;
  endtask

  task automatic do_reset();
    rst_ni = 0;
    repeat (3) @(negedge clk);
    check("R8", trig_o, 1'b0);
    rst_ni = 1;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    // R8: empty table, nothing triggers
    cur_req = "R8";
    sample(16'h0000); sample(16'h1234); sample(16'hFFFF);
    repeat (2) @(negedge clk);

    // R1: masked match on port 0, fn = bit 0
    cur_req = "R1";
    load_fn(0);
    sample(16'h5555);
    cfg_write(0, 1, 16'h00FF);
    cfg_write(0, 0, 16'h1234);
    sample(16'hAB34); sample(16'h1235); sample(16'h0034); sample(16'h3400);
    @(negedge clk);

    // R2: range on port 1, fn = bit 4
    cur_req = "R2";
    load_fn(4);
    cfg_write(1, 2, 16'h0100);
    cfg_write(1, 3, 16'h0200);
    sample(16'h00FF); sample(16'h0100); sample(16'h0180);
    sample(16'h0200); sample(16'h0201); sample(16'h8000);
    cfg_write(1, 2, 16'h0300);
    sample(16'h0200); sample(16'h0300);
    @(negedge clk);

    // R3: edge on port 0, fn = bit 2
    cur_req = "R3";
    load_fn(2);
    sample(16'h0000);
    sample(16'h0000);
    cfg_write(0, 4, 16'h0001);
    cfg_write(0, 5, 16'h0002);
    cfg_write(0, 6, 16'h0100);
    sample(16'h0001); sample(16'h0001); sample(16'h0000);
    sample(16'h0002); sample(16'h0000); sample(16'h0100);
    sample(16'h0000); sample(16'hF0F0); sample(16'h0000);

    // R4: invalid cycles keep previous sample
    cur_req = "R4";
    smp_data_i = 16'h0001; @(negedge clk);
    smp_data_i = 16'h0000; @(negedge clk);
    sample(16'h0001);
    smp_data_i = 16'h0000; @(negedge clk);
    sample(16'h0001);
    // first valid sample after reset has no edge
    do_reset();
    load_fn(2);
    cfg_write(0, 6, 16'hFFFF);
    sample(16'hFFFF); sample(16'hFFFF); sample(16'h0000);

    // R5: term0 AND edge1 -> index bits 0 and 5
    cur_req = "R5";
    cfg_write(0, 6, 16'h0000);
    cfg_write(0, 1, 16'hFF00);
    cfg_write(0, 0, 16'hA500);
    cfg_write(1, 4, 16'h0080);
    for (int a = 0; a < TD; a++) tbl_write(a, a[0] && a[5]);
    sample(16'hA500); sample(16'hA580); sample(16'hA580);
    sample(16'h0000); sample(16'h0080); sample(16'hA500); sample(16'hA5FF);

    // R9: code 7 and wrong-port writes leave port 0 match unchanged
    cur_req = "R9";
    load_fn(0);
    cfg_write(0, 7, 16'hFFFF);
    cfg_write(1, 0, 16'h0000);
    cfg_write(1, 1, 16'hFFFF);
    sample(16'hA512); sample(16'h0012);
    cfg_write(0, 1, 16'hFFFF);
    sample(16'hA512); sample(16'hA500);

    // R6: table write in the same cycle as the sample
    cur_req = "R6";
    load_fn(3);
    cfg_write(1, 1, 16'h0000);
    smp_valid_i = 1; smp_data_i = 16'h1111;
    tbl_we_i = 1; tbl_addr_i = HW'(calc_idx(16'h1111)); tbl_dat_i = ~m_tbl[calc_idx(16'h1111)];
    @(negedge clk);
    tbl_we_i = 0;
    sample(16'h1111);
    sample(16'h1111);

    // R7: random traffic
    cur_req = "R7";
    for (int a = 0; a < TD; a++) tbl_write(a, 1'($urandom));
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom_range(0, 99));
      smp_valid_i = $urandom_range(0, 2) != 0;
      smp_data_i  = (r < 50) ? DW'($urandom_range(0, 7) << 6) : DW'($urandom);
      cfg_we_i    = r >= 92;
      cfg_port_i  = PW'($urandom);
      cfg_field_i = 3'($urandom);
      cfg_wdata_i = (r & 1) ? DW'($urandom) : DW'($urandom_range(0, 7) << 6);
      tbl_we_i    = r < 6;
      tbl_addr_i  = HW'($urandom);
      tbl_dat_i   = 1'($urandom);
      @(negedge clk);
    end
    smp_valid_i = 0; cfg_we_i = 0; tbl_we_i = 0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule